// File: doc/BRIEF.md
# CPU-side endpoint FIFO access port

This block lets a host processor reach the packet buffers of a USB device controller's endpoints through two registers. A select register picks one endpoint and sets how data moves: 16-bit or 8-bit transfers, the byte order of 16-bit transfers, and how the remaining-length count behaves on reads. A data register then reads bytes from a receive (OUT) buffer or writes bytes into a transmit (IN) buffer. Each endpoint keeps its own read pointer, write pointer, byte count, remaining length and overflow flag, so switching endpoints never loses state.

The select register also carries a one-shot rewind action. On an OUT endpoint it moves the read pointer back to the start. On an IN endpoint it moves the write pointer back to the start. The serial engine side is not part of the block. OUT buffers are loaded one byte per cycle through a fill port. IN buffer contents can be read back through a drain port.

Top module: `epf_cpu_port`

## Requirements
- R1: The select register sits at address 0x40 and reads 0x0000 after hardware reset. It reads back the stored fields at fixed positions: count mode at bit 15, byte swap at bit 7, narrow width at bit 6, endpoint code at bits 3:0.
- R2: Bits 14:13, 11:8 and 5:4 of the select register, and the rewind bit 12, always read as 0, and writing 1 to them stores nothing.
- R3: Endpoint codes 1 to 6 are valid. With the default parameters, endpoints 2, 4 and 6 are IN buffers and endpoints 1, 3 and 5 are OUT buffers. While the code is 0 or above 6, a read of the data register (address 0x42) returns 0, a write to it changes no buffer, and the remaining length shows 0.
- R4: With count mode 0, a data read leaves the remaining length unchanged, except for the read that takes the last stored byte, which sets it to 0.
- R5: With count mode 1, each data read lowers the remaining length by 1 in 8-bit mode and by 2 in 16-bit mode, and it never goes below 0.
- R6: In 16-bit mode with byte swap 0, the earlier byte is on bits 7:0. With byte swap 1, the earlier byte is on bits 15:8. In 8-bit mode the byte is on bits 7:0 and bits 15:8 are 0, whatever the swap bit holds.
- R7: Width bit 0 selects 16-bit access and width bit 1 selects 8-bit access. The force_byte input, when high, forces 8-bit access whatever the width bit holds.
- R8: In 16-bit mode, when one byte is left, a read returns that byte in the first-byte lane with the other lane 0. The read pointer moves by one and the remaining length becomes 0.
- R9: Writing the select register with bit 12 set rewinds the endpoint named in that same write. On an OUT endpoint the read pointer returns to 0 and the remaining length returns to the stored byte count. On an IN endpoint the write pointer and the remaining length return to 0. Writing bit 12 as 0 changes no pointer.
- R10: Each endpoint keeps its own pointers, byte count and remaining length, and selecting another endpoint shows that endpoint's state unchanged.
- R11: A data write to an IN endpoint stores 1 byte in 8-bit mode and 2 bytes in 16-bit mode, in the lane order of R6, and the remaining length equals the bytes stored. A byte past the 16-byte capacity is dropped and sets that endpoint's overflow bit (ovf bit n-1 for endpoint n). The bit stays set until hardware reset.
- R12: Reading the data register on an IN endpoint returns 0. Writing it on an OUT endpoint is ignored. Reading an OUT endpoint whose bytes are all consumed returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cpu_addr | input | 8 | Register address (0x40 select, 0x42 data) |
| cpu_rd | input | 1 | Read strobe; side effects at the clock edge |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the addressed register (combinational) |
| force_byte | input | 1 | Forces 8-bit data access when high |
| fill_valid | input | 1 | Appends fill_byte to an OUT endpoint buffer |
| fill_ep | input | 4 | Endpoint code for the fill |
| fill_byte | input | 8 | Byte to append |
| drain_ep | input | 4 | Endpoint code to inspect |
| drain_idx | input | 4 | Byte index to inspect |
| drain_byte | output | 8 | Stored byte at drain_ep and drain_idx |
| rem_len | output | 5 | Remaining length of the selected endpoint |
| ovf | output | 6 | Sticky overflow bit per endpoint |

## Verification
The bench targets the final read of an odd-length packet in 16-bit mode. A wrong design would return a stale second byte, put the byte in the wrong lane, or wrap the count below zero. It also swaps between endpoints part-way through a packet, where a shared pointer would resume at the wrong byte. It checks rewind on both buffer directions, where mixing up the pointers would replay transmit data or lose received data. It fills an IN buffer past capacity, where a missing guard would wrap the write pointer and overwrite the first bytes without raising overflow.

// File: rtl/epf_pkg.sv
package epf_pkg;

    // Bit positions of the select register fields (fixed by the register layout)
    localparam int SEL_CNT_BIT  = 15;
    localparam int SEL_RWND_BIT = 12;
    localparam int SEL_SWAP_BIT = 7;
    localparam int SEL_BYTE_BIT = 6;

    typedef struct packed {
        logic       rd_count;   // 1: count down on every data read
        logic       swap;       // 1: earlier byte in the upper lane
        logic       byte_mode;  // 1: 8-bit data access
        logic [3:0] ep;         // endpoint code
    } epf_cfg_t;

endpackage

// File: rtl/epf_sel_reg.sv
module epf_sel_reg
    import epf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  epf_cfg_t  wr_cfg,
    output epf_cfg_t  cfg,
    output logic [15:0] rd_val
);

    typedef struct packed {
        epf_cfg_t cfg;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cfg = wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;

    // Reserved bits and the one-shot rewind bit read as zero
    always_comb begin
        rd_val               = '0;
        rd_val[SEL_CNT_BIT]  = st_q.cfg.rd_count;
        rd_val[SEL_SWAP_BIT] = st_q.cfg.swap;
        rd_val[SEL_BYTE_BIT] = st_q.cfg.byte_mode;
        rd_val[3:0]          = st_q.cfg.ep;
    end

endmodule

// File: rtl/epf_lane.sv
module epf_lane (
    input  logic        wide,
    input  logic        swap,
    input  logic        have2,
    input  logic [7:0]  rb0,
    input  logic [7:0]  rb1,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic [7:0]  wb0,
    output logic [7:0]  wb1
);

    // Read steering: rb0 is the earlier byte in the buffer
    always_comb begin
        if (!wide) begin
            rdata = {8'h00, rb0};
        end else if (have2) begin
            rdata = swap ? {rb0, rb1} : {rb1, rb0};
        end else begin
            rdata = swap ? {rb0, 8'h00} : {8'h00, rb0};
        end
    end

    // Write steering: wb0 is stored first
    always_comb begin
        if (wide && swap) begin
            wb0 = wdata[15:8];
            wb1 = wdata[7:0];
        end else begin
            wb0 = wdata[7:0];
            wb1 = wdata[15:8];
        end
    end

endmodule

// File: rtl/epf_cpu_port.sv
module epf_cpu_port
    import epf_pkg::*;
#(
    parameter int                NUM_EP    = 6,
    parameter int                BUF_BYTES = 16,      // power of two, at least 2
    parameter logic [7:0]        SEL_ADDR  = 8'h40,
    parameter logic [7:0]        DATA_ADDR = 8'h42,
    parameter logic [NUM_EP-1:0] EP_IS_IN  = 6'b101010 // bit n-1 set: endpoint n transmits
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [7:0]                     cpu_addr,
    input  logic                           cpu_rd,
    input  logic                           cpu_wr,
    input  logic [15:0]                    cpu_wdata,
    output logic [15:0]                    cpu_rdata,
    input  logic                           force_byte,
    input  logic                           fill_valid,
    input  logic [3:0]                     fill_ep,
    input  logic [7:0]                     fill_byte,
    input  logic [3:0]                     drain_ep,
    input  logic [$clog2(BUF_BYTES)-1:0]   drain_idx,
    output logic [7:0]                     drain_byte,
    output logic [$clog2(BUF_BYTES+1)-1:0] rem_len,
    output logic [NUM_EP-1:0]              ovf
);

    localparam int IW  = $clog2(BUF_BYTES);
    localparam int CW  = $clog2(BUF_BYTES + 1);
    localparam int IXW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
    localparam logic [CW-1:0] CAP = CW'(BUF_BYTES);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    typedef struct packed {
        logic [CW-1:0] cnt;   // bytes stored (OUT)
        logic [CW-1:0] rptr;  // next byte to read (OUT)
        logic [CW-1:0] wptr;  // next byte to write (IN)
        logic [CW-1:0] len;   // remaining-length count
        logic          ovf;   // sticky overflow (IN)
    } ep_st_t;

    ep_st_t     ep_d  [NUM_EP];
    ep_st_t     ep_q  [NUM_EP];
    logic [7:0] mem_d [NUM_EP][BUF_BYTES];
    logic [7:0] mem_q [NUM_EP][BUF_BYTES];

    function automatic logic code_ok(input logic [3:0] code);
        return (code != 4'd0) && (int'(code) <= NUM_EP);
    endfunction

    function automatic logic [IXW-1:0] code_idx(input logic [3:0] code);
        return code_ok(code) ? IXW'(code - 4'd1) : '0;
    endfunction

    // ---------------- select register ----------------
    epf_cfg_t    cfg;
    epf_cfg_t    wr_cfg;
    logic [15:0] sel_rd;
    logic        sel_we;
    logic        rewind;

    assign sel_we = cpu_wr && (cpu_addr == SEL_ADDR);
    assign rewind = sel_we && cpu_wdata[SEL_RWND_BIT];

    always_comb begin
        wr_cfg.rd_count  = cpu_wdata[SEL_CNT_BIT];
        wr_cfg.swap      = cpu_wdata[SEL_SWAP_BIT];
        wr_cfg.byte_mode = cpu_wdata[SEL_BYTE_BIT];
        wr_cfg.ep        = cpu_wdata[3:0];
    end

    epf_sel_reg u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sel_we),
        .wr_cfg (wr_cfg),
        .cfg    (cfg),
        .rd_val (sel_rd)
    );

    // ---------------- selected endpoint view ----------------
    logic           s_ok;
    logic [IXW-1:0] sidx;
    logic           s_in;
    ep_st_t         cur;
    logic [CW-1:0]  avail;
    logic           wide;
    logic           have2;
    logic [7:0]     rb0, rb1;
    logic [15:0]    lane_rdata;
    logic [7:0]     wb0, wb1;
    logic           data_rd, data_wr;

    assign s_ok  = code_ok(cfg.ep);
    assign sidx  = code_idx(cfg.ep);
    assign s_in  = EP_IS_IN[sidx];
    assign cur   = ep_q[sidx];
    assign avail = cur.cnt - cur.rptr;
    assign wide  = !(cfg.byte_mode || force_byte);
    assign have2 = wide && (avail >= TWO);
    assign rb0   = (avail != '0) ? mem_q[sidx][cur.rptr[IW-1:0]] : 8'h00;
    assign rb1   = have2 ? mem_q[sidx][IW'(cur.rptr + ONE)] : 8'h00;

    assign data_rd = cpu_rd && (cpu_addr == DATA_ADDR) && s_ok && !s_in;
    assign data_wr = cpu_wr && (cpu_addr == DATA_ADDR) && s_ok && s_in;

    epf_lane u_lane (
        .wide  (wide),
        .swap  (cfg.swap),
        .have2 (have2),
        .rb0   (rb0),
        .rb1   (rb1),
        .wdata (cpu_wdata),
        .rdata (lane_rdata),
        .wb0   (wb0),
        .wb1   (wb1)
    );

    always_comb begin
        if (cpu_addr == SEL_ADDR) begin
            cpu_rdata = sel_rd;
        end else if ((cpu_addr == DATA_ADDR) && s_ok && !s_in) begin
            cpu_rdata = lane_rdata;
        end else begin
            cpu_rdata = '0;
        end
    end

    assign rem_len    = s_ok ? cur.len : '0;
    assign drain_byte = code_ok(drain_ep) ? mem_q[code_idx(drain_ep)][drain_idx] : 8'h00;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ovf
        assign ovf[g] = ep_q[g].ovf;
    end

    // ---------------- next state ----------------
    always_comb begin
        logic [CW-1:0]  step;
        logic [CW-1:0]  nxt;
        logic [CW-1:0]  wp;
        logic           ov;
        logic [IXW-1:0] ridx;
        logic [IXW-1:0] fidx;

        ep_d  = ep_q;
        mem_d = mem_q;
        step  = wide ? TWO : ONE;
        ridx  = code_idx(cpu_wdata[3:0]);
        fidx  = code_idx(fill_ep);
        nxt   = cur.rptr;
        wp    = cur.wptr;
        ov    = cur.ovf;

        // OUT read: advance pointer, update count per mode
        if (data_rd && (avail != '0)) begin
            nxt = cur.rptr + (have2 ? TWO : ONE);
            ep_d[sidx].rptr = nxt;
            if (nxt == cur.cnt) begin
                ep_d[sidx].len = '0;
            end else if (cfg.rd_count) begin
                ep_d[sidx].len = (cur.len > step) ? (cur.len - step) : '0;
            end
        end

        // IN write: store up to two bytes, drop beyond capacity
        if (data_wr) begin
            if (wp < CAP) begin
                mem_d[sidx][wp[IW-1:0]] = wb0;
                wp = wp + ONE;
            end else begin
                ov = 1'b1;
            end
            if (wide) begin
                if (wp < CAP) begin
                    mem_d[sidx][wp[IW-1:0]] = wb1;
                    wp = wp + ONE;
                end else begin
                    ov = 1'b1;
                end
            end
            ep_d[sidx].wptr = wp;
            ep_d[sidx].len  = wp;
            ep_d[sidx].ovf  = ov;
        end

        // Rewind acts on the endpoint named in the same write
        if (rewind && code_ok(cpu_wdata[3:0])) begin
            if (EP_IS_IN[ridx]) begin
                ep_d[ridx].wptr = '0;
                ep_d[ridx].len  = '0;
            end else begin
                ep_d[ridx].rptr = '0;
                ep_d[ridx].len  = ep_d[ridx].cnt;
            end
        end

        // Test-side fill of OUT buffers
        if (fill_valid && code_ok(fill_ep) && !EP_IS_IN[fidx] && (ep_d[fidx].cnt < CAP)) begin
            mem_d[fidx][ep_d[fidx].cnt[IW-1:0]] = fill_byte;
            ep_d[fidx].cnt = ep_d[fidx].cnt + ONE;
            ep_d[fidx].len = ep_d[fidx].len + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_EP; i++) begin
                ep_q[i] <= '0;
            end
        end else begin
            ep_q <= ep_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/epf_cpu_port_chk.sv
module epf_cpu_port_chk #(
    parameter int         NUM_EP    = 6,
    parameter int         CW        = 5,
    parameter int         BUF_BYTES = 16,
    parameter logic [7:0] SEL_ADDR  = 8'h40,
    parameter logic [7:0] DATA_ADDR = 8'h42
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [15:0]       cpu_rdata,
    input logic              fill_valid,
    input logic [CW-1:0]     rem_len,
    input logic [NUM_EP-1:0] ovf,
    input logic [3:0]        sel_ep
);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == SEL_ADDR) |-> ((cpu_rdata & 16'h7F30) == 16'h0000));

    // R3
    bad_ep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_ep == 4'd0) || (int'(sel_ep) > NUM_EP)) |->
            ((rem_len == '0) && ((cpu_addr != DATA_ADDR) || (cpu_rdata == 16'h0000))));

    // R5
    rd_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !fill_valid && (cpu_addr == DATA_ADDR)) |=>
            (rem_len <= $past(rem_len)));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf != '0) |=> ((ovf & $past(ovf)) == $past(ovf)));

    // R11
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rem_len) <= BUF_BYTES));

endmodule

bind epf_cpu_port epf_cpu_port_chk #(
    .NUM_EP    (NUM_EP),
    .CW        ($clog2(BUF_BYTES + 1)),
    .BUF_BYTES (BUF_BYTES),
    .SEL_ADDR  (SEL_ADDR),
    .DATA_ADDR (DATA_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_rdata  (cpu_rdata),
    .fill_valid (fill_valid),
    .rem_len    (rem_len),
    .ovf        (ovf),
    .sel_ep     (cfg.ep)
);

// File: tb/epf_cpu_port_tb.sv
`timescale 1ns/1ps
module epf_cpu_port_tb;

    localparam logic [7:0] SEL = 8'h40;
    localparam logic [7:0] DAT = 8'h42;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [15:0] cpu_wdata;
    logic [15:0] cpu_rdata;
    logic        force_byte;
    logic        fill_valid;
    logic [3:0]  fill_ep;
    logic [7:0]  fill_byte;
    logic [3:0]  drain_ep;
    logic [3:0]  drain_idx;
    logic [7:0]  drain_byte;
    logic [4:0]  rem_len;
    logic [5:0]  ovf;

    epf_cpu_port u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .force_byte(force_byte),
        .fill_valid(fill_valid), .fill_ep(fill_ep), .fill_byte(fill_byte),
        .drain_ep(drain_ep), .drain_idx(drain_idx), .drain_byte(drain_byte),
        .rem_len(rem_len), .ovf(ovf)
    );

    always #2 clk = ~clk;

    // ---------------- reference model ----------------
    int         m_cnt [1:6];
    int         m_rptr[1:6];
    int         m_wptr[1:6];
    int         m_len [1:6];
    bit         m_ovf [1:6];
    logic [7:0] m_mem [1:6][0:15];
    logic [7:0] in_q  [1:6][$];
    bit         m_rcnt, m_swap, m_byte;
    int         m_ep;

    int    checks = 0;
    int    errors = 0;
    string req = "R1";

    function automatic bit ep_valid(int e);
        return (e >= 1) && (e <= 6);
    endfunction

    function automatic bit ep_in(int e);
        return (e == 2) || (e == 4) || (e == 6);
    endfunction

    function automatic logic [15:0] exp_rdata();
        int av;
        bit wide;
        logic [7:0] b0, b1;
        if (cpu_addr == SEL)
            return {m_rcnt, 7'd0, m_swap, m_byte, 2'b00, 4'(m_ep)};
        if (cpu_addr != DAT || !ep_valid(m_ep) || ep_in(m_ep)) return 16'h0000;
        av = m_cnt[m_ep] - m_rptr[m_ep];
        if (av == 0) return 16'h0000;
        wide = !(m_byte || force_byte);
        b0 = m_mem[m_ep][m_rptr[m_ep]];
        if (!wide) return {8'h00, b0};
        if (av >= 2) begin
            b1 = m_mem[m_ep][m_rptr[m_ep] + 1];
            return m_swap ? {b0, b1} : {b1, b0};
        end
        return m_swap ? {b0, 8'h00} : {8'h00, b0};
    endfunction

    function automatic logic [5:0] exp_ovf();
        logic [5:0] v;
        for (int i = 1; i <= 6; i++) v[i-1] = m_ovf[i];
        return v;
    endfunction

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic model_update();
        int e, take, step, n;
        bit wide;
        logic [7:0] b [2];
        e    = m_ep;
        wide = !(m_byte || force_byte);
        step = wide ? 2 : 1;
        if (cpu_rd && cpu_addr == DAT && ep_valid(e) && !ep_in(e) && m_cnt[e] > m_rptr[e]) begin
            take = (wide && (m_cnt[e] - m_rptr[e]) >= 2) ? 2 : 1;
            m_rptr[e] += take;
            if (m_rptr[e] == m_cnt[e]) m_len[e] = 0;
            else if (m_rcnt) m_len[e] = (m_len[e] > step) ? m_len[e] - step : 0;
        end
        if (cpu_wr && cpu_addr == DAT && ep_valid(e) && ep_in(e)) begin
            n = step;
            if (wide && m_swap) begin b[0] = cpu_wdata[15:8]; b[1] = cpu_wdata[7:0]; end
            else                begin b[0] = cpu_wdata[7:0];  b[1] = cpu_wdata[15:8]; end
            for (int k = 0; k < n; k++) begin
                if (m_wptr[e] < 16) begin
                    m_mem[e][m_wptr[e]] = b[k];
                    in_q[e].push_back(b[k]);
                    m_wptr[e]++;
                end else begin
                    m_ovf[e] = 1'b1;
                end
            end
            m_len[e] = m_wptr[e];
        end
        if (cpu_wr && cpu_addr == SEL) begin
            m_rcnt = cpu_wdata[15];
            m_swap = cpu_wdata[7];
            m_byte = cpu_wdata[6];
            m_ep   = int'(cpu_wdata[3:0]);
            if (cpu_wdata[12] && ep_valid(m_ep)) begin
                if (ep_in(m_ep)) begin
                    m_wptr[m_ep] = 0; m_len[m_ep] = 0; in_q[m_ep].delete();
                end else begin
                    m_rptr[m_ep] = 0; m_len[m_ep] = m_cnt[m_ep];
                end
            end
        end
        if (fill_valid && ep_valid(int'(fill_ep)) && !ep_in(int'(fill_ep)) && m_cnt[fill_ep] < 16) begin
            m_mem[fill_ep][m_cnt[fill_ep]] = fill_byte;
            m_cnt[fill_ep]++;
            m_len[fill_ep]++;
        end
    endtask

    // One clock: drive at the falling edge, compare before the rising edge
    task automatic cyc(bit rd, bit wr, logic [7:0] addr, logic [15:0] wd,
                       bit fv, logic [3:0] fe, logic [7:0] fb);
        int de;
        cpu_rd = rd; cpu_wr = wr; cpu_addr = addr; cpu_wdata = wd;
        fill_valid = fv; fill_ep = fe; fill_byte = fb;
        #1;
        chk(req, "cpu_rdata", 32'(cpu_rdata), 32'(exp_rdata()));
        chk(req, "rem_len", 32'(rem_len), ep_valid(m_ep) ? 32'(m_len[m_ep]) : 32'd0);
        chk(req, "ovf", 32'(ovf), 32'(exp_ovf()));
        de = int'(drain_ep);
        if (ep_valid(de) && int'(drain_idx) < in_q[de].size())
            chk(req, "drain_byte", 32'(drain_byte), 32'(in_q[de][drain_idx]));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic sel_write(logic [15:0] v); cyc(0, 1, SEL, v, 0, 0, 0);     endtask
    task automatic dread();                    cyc(1, 0, DAT, 0, 0, 0, 0);     endtask
    task automatic dwrite(logic [15:0] v);    cyc(0, 1, DAT, v, 0, 0, 0);     endtask
    task automatic peek(logic [7:0] a);        cyc(0, 0, a, 0, 0, 0, 0);       endtask
    task automatic fill(logic [3:0] e, logic [7:0] b); cyc(0, 0, 8'h00, 0, 1, e, b); endtask

    task automatic peek_data(string r, logic [15:0] exp);
        cpu_rd = 0; cpu_wr = 0; cpu_addr = DAT; fill_valid = 0;
        #1;
        chk(r, "data value", 32'(cpu_rdata), 32'(exp));
        @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired in %s", req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 1; i <= 6; i++) begin
            m_cnt[i] = 0; m_rptr[i] = 0; m_wptr[i] = 0; m_len[i] = 0; m_ovf[i] = 0;
        end
        m_rcnt = 0; m_swap = 0; m_byte = 0; m_ep = 0;
        rst_n = 0; cpu_addr = 0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = 0;
        force_byte = 0; fill_valid = 0; fill_ep = 0; fill_byte = 0;
        drain_ep = 4'd2; drain_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        req = "R1";
        peek(SEL);
        chk("R1", "ovf after reset", 32'(ovf), 32'd0);
        chk("R1", "rem_len after reset", 32'(rem_len), 32'd0);

        // R2: reserved and rewind bits read zero; R1 field readback
        req = "R2";
        sel_write(16'hFFFF);
        peek(SEL);
        peek_data("R2", 16'h0000);
        cpu_addr = SEL; #1;
        chk("R2", "select readback", 32'(cpu_rdata), 32'h80CF);
        @(negedge clk);

        // R3: invalid endpoint codes
        req = "R3";
        sel_write(16'h0000);
        dread();
        dwrite(16'h1234);
        sel_write(16'h0007);
        dread();
        chk("R3", "rem_len invalid ep", 32'(rem_len), 32'd0);

        // Fill OUT buffers: ep1 7 bytes, ep3 16 bytes, ep5 5 bytes
        req = "R10";
        for (int i = 0; i < 7; i++)  fill(4'd1, 8'h10 + 8'(i));
        for (int i = 0; i < 16; i++) fill(4'd3, 8'h30 + 8'(i));
        for (int i = 0; i < 5; i++)  fill(4'd5, 8'h50 + 8'(i));

        // R4/R6/R8: count mode 0, 16-bit little-endian, odd tail
        req = "R4";
        sel_write(16'h0001);
        chk("R4", "rem_len start", 32'(rem_len), 32'd7);
        peek_data("R6", 16'h1110);
        dread(); dread(); dread();
        chk("R4", "rem_len unchanged", 32'(rem_len), 32'd7);
        req = "R8";
        peek_data("R8", 16'h0016);
        dread();
        chk("R8", "rem_len after tail", 32'(rem_len), 32'd0);
        req = "R12";
        peek_data("R12", 16'h0000);
        dread();
        chk("R12", "exhausted rem_len", 32'(rem_len), 32'd0);

        // R9/R5/R6: rewind, count mode 1, swapped order
        req = "R9";
        sel_write(16'h9081);
        chk("R9", "rem_len after OUT rewind", 32'(rem_len), 32'd7);
        req = "R5";
        peek_data("R6", 16'h1011);
        dread();
        chk("R5", "rem_len -2", 32'(rem_len), 32'd5);
        dread(); dread();
        peek_data("R8", 16'h1600);
        dread();
        chk("R5", "rem_len no underflow", 32'(rem_len), 32'd0);

        // R7: width bit and forced byte mode
        req = "R7";
        sel_write(16'h90C1);
        peek_data("R7", 16'h0010);
        dread();
        chk("R5", "rem_len -1", 32'(rem_len), 32'd6);
        sel_write(16'h8001);
        chk("R9", "no rewind on bit 12 clear", 32'(rem_len), 32'd6);
        force_byte = 1;
        peek_data("R7", 16'h0011);
        dread();
        chk("R7", "forced byte rem_len", 32'(rem_len), 32'd5);
        force_byte = 0;

        // R10: independent endpoint state
        req = "R10";
        sel_write(16'h8003);
        chk("R10", "ep3 rem_len", 32'(rem_len), 32'd16);
        dread();
        chk("R10", "ep3 rem_len after read", 32'(rem_len), 32'd14);
        sel_write(16'h8001);
        chk("R10", "ep1 rem_len kept", 32'(rem_len), 32'd5);
        peek_data("R10", 16'h1312);
        sel_write(16'h0005);
        chk("R10", "ep5 rem_len", 32'(rem_len), 32'd5);

        // R12: wrong-direction accesses ignored
        req = "R12";
        sel_write(16'h0002);
        peek_data("R12", 16'h0000);
        dread();
        sel_write(16'h8001);
        dwrite(16'hABCD);
        chk("R12", "OUT write ignored", 32'(rem_len), 32'd5);
        peek_data("R12", 16'h1312);

        // R11: IN writes, lane order, overflow
        req = "R11";
        sel_write(16'h0002);
        dwrite(16'hBBAA);
        sel_write(16'h0082);
        dwrite(16'hCCDD);
        sel_write(16'h0042);
        dwrite(16'h12EE);
        chk("R11", "IN rem_len", 32'(rem_len), 32'd5);
        sel_write(16'h0002);
        for (int k = 0; k < 6; k++) dwrite({8'h71 + 8'(2*k), 8'h70 + 8'(2*k)});
        chk("R11", "IN rem_len full", 32'(rem_len), 32'd16);
        chk("R11", "overflow bit ep2", 32'(ovf), 32'h02);
        for (int i = 0; i < 16; i++) begin
            drain_idx = 4'(i);
            peek(8'h00);
        end
        drain_idx = 0; #1;
        chk("R11", "drain byte 0", 32'(drain_byte), 32'hAA);
        drain_idx = 2; #1;
        chk("R6", "swapped write first byte", 32'(drain_byte), 32'hCC);
        drain_idx = 4; #1;
        chk("R7", "byte write", 32'(drain_byte), 32'hEE);
        @(negedge clk);

        // R9: IN rewind keeps the sticky flag
        req = "R9";
        sel_write(16'h1002);
        chk("R9", "IN rewind rem_len", 32'(rem_len), 32'd0);
        chk("R11", "overflow sticky", 32'(ovf), 32'h02);
        dwrite(16'h7788);
        drain_idx = 0;
        peek(8'h00);
        chk("R9", "rewritten byte 0", 32'(drain_byte), 32'h88);
        chk("R9", "IN rem_len after rewrite", 32'(rem_len), 32'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule